// File: doc/BRIEF.md
# Serial Boot-Download Sequencer

This block runs the download stage of a boot-time serial loader. It starts once the UART bit rate has been locked and the lock byte has gone out. It then waits for the host to confirm with 0x55. After that it has an external flash controller report whether the user flash area is blank. If the area holds any data, the block has the controller erase every block. An erase failure ends the session with a single 0xFF error byte.

When the flash is ready, the block announces readiness with 0xAA and takes a two-byte length. It then takes that many program bytes. Every length byte and every program byte is echoed to the host. The program bytes are written to consecutive RAM addresses starting at the load base. When the last byte is done, the block sends 0xAA and raises a one-cycle start pulse that carries the entry address.

The UART and the flash controller sit outside this block. The block sees the UART as a byte stream with valid and ready in each direction, and sees the flash controller as two request and done handshakes.

Top module: `boot_dl_seq`

## Requirements
- R1: During and right after reset, all of the following are low: `rx_ready`, `tx_valid`, `flash_chk_req`, `flash_erase_req`, `ram_we`, `start_pulse` and `halted`.
- R2: After `rate_locked` is seen, the block accepts host bytes. It ignores every byte other than 0x55: it sends nothing, raises no flash request and keeps accepting bytes. A 0x55 byte moves it on to the flash check.
- R3: The block holds `flash_chk_req` until `flash_chk_done`. If `flash_blank` is high on that cycle, it raises no erase request and goes straight to the ready byte.
- R4: If the flash is not blank, the block holds `flash_erase_req` until `flash_erase_done`. If `flash_erase_ok` is high on that cycle, it goes on to the ready byte.
- R5: If the erase fails, the block sends exactly one 0xFF byte and then stays halted (`halted` high). In the halted state it accepts no bytes and sends nothing more.
- R6: The ready byte is 0xAA. The length then arrives as two bytes, high byte first (for example 256 is sent as 0x01 then 0x00). Each length byte is echoed unchanged.
- R7: A length of 0, or of more than 910, is rejected after both length bytes have been echoed. The block sends one 0xFF byte and halts as in R5.
- R8: Program byte i (counted from 0) is written with `ram_we` to address 0xFBE0+i and echoed unchanged. The last byte of a 910-byte load lands at 0xFF6D.
- R9: While an echo or a status byte is waiting to be sent (`tx_valid` high), `rx_ready` stays low.
- R10: After the last program echo, the block sends one 0xAA byte. It then raises `start_pulse` for exactly one cycle with `start_addr` = 0xFBE0. After that it does nothing more.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_locked | input | 1 | UART bit rate locked and lock byte sent |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block takes the received byte |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Transmitter takes the byte |
| flash_chk_req | output | 1 | Request a blank check of the user flash area |
| flash_chk_done | input | 1 | Blank check finished (one-cycle) |
| flash_blank | input | 1 | Area reads all 0xFF, valid with done |
| flash_erase_req | output | 1 | Request an erase of all flash blocks |
| flash_erase_done | input | 1 | Erase finished (one-cycle) |
| flash_erase_ok | input | 1 | Erase succeeded, valid with done |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| start_pulse | output | 1 | One-cycle start of the loaded program |
| start_addr | output | 16 | Entry address for the start |
| halted | output | 1 | Session stopped on an error |

## Verification
The assertions assume the flash controller pulses each done signal for one cycle, and only while the matching request is high. They also assume `rx_data` is held steady whenever `rx_valid` is high. The bench answers each flash request a few cycles after it sees the request, and only then. It keeps each received byte on the pins until the block accepts it, and lowers `rx_valid` in the same step. To exercise the hold rule, `tx_ready` stalls on a fixed pattern. Near the halted state, bytes are offered only to check that `rx_ready` stays low.

// File: rtl/boot_dl_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes 8-bit UART bytes and a 16-bit RAM address space.
package boot_dl_pkg;
    localparam logic [7:0] CONF_BYTE  = 8'h55;
    localparam logic [7:0] READY_BYTE = 8'hAA;
    localparam logic [7:0] ERROR_BYTE = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE,      // waiting for rate lock
        S_CONF,      // waiting for host confirmation
        S_CHK,       // flash blank check in progress
        S_ERASE,     // flash erase in progress
        S_RDY_TX,    // sending ready byte
        S_LEN_HI,    // receiving length high byte
        S_LEN_HI_EC, // echoing length high byte
        S_LEN_LO,    // receiving length low byte
        S_LEN_LO_EC, // echoing length low byte
        S_DATA,      // receiving program byte
        S_DATA_EC,   // echoing program byte
        S_DONE_TX,   // sending completion byte
        S_START,     // start pulse cycle
        S_FIN,       // finished, inert
        S_ERR_TX,    // sending error byte
        S_HALT       // halted on error
    } seq_state_t;
endpackage

// File: rtl/boot_dl_len.sv
// Length capture: stores the two length bytes, high byte first, and
// reports whether the assembled count lies in 1..MAX_LEN.
// Assumes the capture strobes come only on accepted RX bytes.
module boot_dl_len #(
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 910
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_hi,
    input  logic             cap_lo,
    input  logic [7:0]       byte_in,
    output logic [LEN_W-1:0] len,
    output logic             len_ok
);
    localparam int HALF = LEN_W / 2;

    logic [HALF-1:0] hi_q;
    logic [HALF-1:0] lo_q;

    // Capture each half of the count as it arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_hi) hi_q <= byte_in;
            if (cap_lo) lo_q <= byte_in;
        end
    end

    // Assemble the count and apply the range rule.
    always_comb begin
        len    = {hi_q, lo_q};
        len_ok = (len != '0) && (len <= LEN_W'(MAX_LEN));
    end
endmodule

// File: rtl/boot_dl_ctr.sv
// Load counter: holds the RAM write address and the remaining byte
// count. A load resets both; each step advances the address and
// decrements the count. Assumes step never comes while the count is zero.
module boot_dl_ctr #(
    parameter int          ADDR_W  = 16,
    parameter int          LEN_W   = 16,
    parameter int          MAX_LEN = 910,
    parameter logic [15:0] BASE    = 16'hFBE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  len,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              zero
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BASE) + ADDR_W'(MAX_LEN - 1);

    logic [LEN_W-1:0] remain_q;

    // Track the write address and the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= ADDR_W'(BASE);
            remain_q <= '0;
        end else if (load) begin
            addr     <= ADDR_W'(BASE);
            remain_q <= len;
        end else if (step) begin
            addr     <= addr + 1'b1;
            remain_q <= remain_q - 1'b1;
        end
    end

    // Flag when the remaining count is exhausted.
    always_comb zero = (remain_q == '0);

    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (addr >= ADDR_W'(BASE)) && (addr <= LAST_ADDR)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !zero); // R8
endmodule

// File: rtl/boot_dl_seq.sv
// Boot download sequencer: confirmation, flash check and erase,
// length and data reception with echo, RAM load and start.
// Assumes one-cycle done pulses from the flash controller, and that
// rx_data is held steady while rx_valid is high.
module boot_dl_seq
    import boot_dl_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          LEN_W   = 16,
    parameter int          MAX_LEN = 910,
    parameter logic [15:0] BASE    = 16'hFBE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_locked,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              flash_chk_req,
    input  logic              flash_chk_done,
    input  logic              flash_blank,
    output logic              flash_erase_req,
    input  logic              flash_erase_done,
    input  logic              flash_erase_ok,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              start_pulse,
    output logic [ADDR_W-1:0] start_addr,
    output logic              halted
);
    seq_state_t       state_q, state_d;
    logic [7:0]       echo_q;
    logic             rx_take;
    logic             cap_hi, cap_lo, ctr_load, ctr_step;
    logic [LEN_W-1:0] len;
    logic             len_ok;
    logic             ctr_zero;

    boot_dl_len #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_len (
        .clk(clk), .rst_n(rst_n), .cap_hi(cap_hi), .cap_lo(cap_lo),
        .byte_in(rx_data), .len(len), .len_ok(len_ok)
    );

    boot_dl_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .BASE(BASE)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .len(len),
        .step(ctr_step), .addr(ram_addr), .zero(ctr_zero)
    );

    // Decode handshake outputs from the current state.
    always_comb begin
        rx_ready        = (state_q == S_CONF) || (state_q == S_LEN_HI) ||
                          (state_q == S_LEN_LO) || (state_q == S_DATA);
        rx_take         = rx_ready && rx_valid;
        tx_valid        = (state_q == S_RDY_TX) || (state_q == S_LEN_HI_EC) ||
                          (state_q == S_LEN_LO_EC) || (state_q == S_DATA_EC) ||
                          (state_q == S_DONE_TX) || (state_q == S_ERR_TX);
        unique case (state_q)
            S_RDY_TX, S_DONE_TX: tx_data = READY_BYTE;
            S_ERR_TX:            tx_data = ERROR_BYTE;
            default:             tx_data = echo_q;
        endcase
        flash_chk_req   = (state_q == S_CHK);
        flash_erase_req = (state_q == S_ERASE);
        cap_hi          = (state_q == S_LEN_HI) && rx_valid;
        cap_lo          = (state_q == S_LEN_LO) && rx_valid;
        ctr_load        = (state_q == S_LEN_LO_EC) && tx_ready;
        ctr_step        = (state_q == S_DATA) && rx_valid;
        ram_we          = ctr_step;
        ram_wdata       = rx_data;
        start_pulse     = (state_q == S_START);
        start_addr      = ADDR_W'(BASE);
        halted          = (state_q == S_HALT);
    end

    // Choose the next protocol step.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (rate_locked) state_d = S_CONF;
            S_CONF:      if (rx_take && rx_data == CONF_BYTE) state_d = S_CHK;
            S_CHK:       if (flash_chk_done) state_d = flash_blank ? S_RDY_TX : S_ERASE;
            S_ERASE:     if (flash_erase_done) state_d = flash_erase_ok ? S_RDY_TX : S_ERR_TX;
            S_RDY_TX:    if (tx_ready) state_d = S_LEN_HI;
            S_LEN_HI:    if (rx_take) state_d = S_LEN_HI_EC;
            S_LEN_HI_EC: if (tx_ready) state_d = S_LEN_LO;
            S_LEN_LO:    if (rx_take) state_d = S_LEN_LO_EC;
            S_LEN_LO_EC: if (tx_ready) state_d = len_ok ? S_DATA : S_ERR_TX;
            S_DATA:      if (rx_take) state_d = S_DATA_EC;
            S_DATA_EC:   if (tx_ready) state_d = ctr_zero ? S_DONE_TX : S_DATA;
            S_DONE_TX:   if (tx_ready) state_d = S_START;
            S_START:     state_d = S_FIN;
            S_FIN:       state_d = S_FIN;
            S_ERR_TX:    if (tx_ready) state_d = S_HALT;
            S_HALT:      state_d = S_HALT;
            default:     state_d = S_HALT;
        endcase
    end

    // Register the state and the byte to echo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            echo_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rx_take) echo_q <= rx_data;
        end
    end

    AST_CONF_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONF && rx_valid && rx_data != CONF_BYTE) |=> (state_q == S_CONF)); // R2
    AST_BLANK_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_chk_req && flash_chk_done && flash_blank) |=> !flash_erase_req); // R3
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !tx_valid && !rx_ready)); // R5
    AST_ECHO_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready); // R9
    AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R10
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R11
endmodule

// File: tb/boot_dl_seq_bench.sv
module boot_dl_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_locked = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        flash_chk_req;
    logic        flash_chk_done = 1'b0;
    logic        flash_blank = 1'b0;
    logic        flash_erase_req;
    logic        flash_erase_done = 1'b0;
    logic        flash_erase_ok = 1'b0;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        start_pulse;
    logic [15:0] start_addr;
    logic        halted;

    always #4 clk = ~clk;

    boot_dl_seq u_boot_dl_seq (
        .clk(clk), .rst_n(rst_n), .rate_locked(rate_locked),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .flash_chk_req(flash_chk_req), .flash_chk_done(flash_chk_done),
        .flash_blank(flash_blank), .flash_erase_req(flash_erase_req),
        .flash_erase_done(flash_erase_done), .flash_erase_ok(flash_erase_ok),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .start_pulse(start_pulse), .start_addr(start_addr), .halted(halted)
    );

    int          n_checks = 0;
    int          n_fail = 0;
    logic [7:0]  exp_tx[$];
    string       exp_tag[$];
    logic [15:0] exp_wa[$];
    logic [7:0]  exp_wd[$];
    int          start_cnt = 0;
    int          erase_seen = 0;
    logic        hold_prev = 1'b0;
    logic [7:0]  hold_data = '0;
    int          cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Fixed stall pattern on the transmitter.
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        tx_ready = (cyc % 3) != 0;
    end

    // Reference model: expected byte stream and write stream, compared every clock.
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            chk(!(tx_valid && rx_ready), "R9 rx_ready during tx", int'(rx_ready), 0);
            if (hold_prev) begin
                chk(tx_valid, "R11 tx_valid dropped", int'(tx_valid), 1);
                chk(tx_data == hold_data, "R11 tx_data changed", tx_data, hold_data);
            end
            hold_prev = tx_valid && !tx_ready;
            hold_data = tx_data;
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) chk(0, "R5 unexpected tx", tx_data, 0);
                else begin
                    automatic logic [7:0] e = exp_tx.pop_front();
                    automatic string t = exp_tag.pop_front();
                    chk(tx_data == e, t, tx_data, e);
                end
            end
            if (ram_we) begin
                if (exp_wa.size() == 0) chk(0, "R8 unexpected write", ram_addr, 0);
                else begin
                    automatic logic [15:0] a = exp_wa.pop_front();
                    automatic logic [7:0] d = exp_wd.pop_front();
                    chk(ram_addr == a, "R8 write address", ram_addr, a);
                    chk(ram_wdata == d, "R8 write data", ram_wdata, d);
                end
            end
            if (start_pulse) begin
                start_cnt++;
                chk(start_addr == 16'hFBE0, "R10 start address", start_addr, 16'hFBE0);
            end
            if (flash_erase_req) erase_seen = 1;
        end else hold_prev = 1'b0;
    end

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        rx_data = b; rx_valid = 1'b1;
        do @(negedge clk); while (!rx_ready);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b, input string t);
        exp_tx.push_back(b); exp_tag.push_back(t);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rate_locked = 1'b0; rx_valid = 1'b0;
        exp_tx.delete(); exp_tag.delete(); exp_wa.delete(); exp_wd.delete();
        start_cnt = 0; erase_seen = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!rx_ready && !tx_valid && !flash_chk_req && !flash_erase_req &&
            !ram_we && !start_pulse && !halted, "R1 reset outputs",
            {rx_ready, tx_valid, flash_chk_req, flash_erase_req, ram_we, start_pulse, halted}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic run(input bit blank, input bit ers_ok, input int len);
        automatic bit len_ok = (len != 0) && (len <= 910);
        automatic bit go = blank || ers_ok;
        do_reset();
        if (!go) push_tx(8'hFF, "R5 erase error byte");
        else begin
            push_tx(8'hAA, "R6 ready byte");
            push_tx(len[15:8], "R6 length high echo");
            push_tx(len[7:0], "R6 length low echo");
            if (!len_ok) push_tx(8'hFF, "R7 length reject byte");
            else begin
                for (int i = 0; i < len; i++) begin
                    automatic logic [7:0] d = 8'((i * 7 + 3) ^ (i >> 8));
                    push_tx(d, "R8 data echo");
                    exp_wa.push_back(16'hFBE0 + 16'(i));
                    exp_wd.push_back(d);
                end
                push_tx(8'hAA, "R10 completion byte");
            end
        end
        @(posedge clk); #1 rate_locked = 1'b1;
        send_byte(8'h3C);
        @(negedge clk);
        chk(!tx_valid && !flash_chk_req && rx_ready, "R2 ignored byte",
            {tx_valid, flash_chk_req, rx_ready}, 1);
        send_byte(8'h55);
        do @(negedge clk); while (!flash_chk_req);
        chk(flash_chk_req, "R3 check request", int'(flash_chk_req), 1);
        repeat (2) @(posedge clk);
        #1 flash_chk_done = 1'b1; flash_blank = blank;
        @(posedge clk); #1 flash_chk_done = 1'b0;
        if (!blank) begin
            do @(negedge clk); while (!flash_erase_req);
            chk(flash_erase_req, "R4 erase request", int'(flash_erase_req), 1);
            repeat (3) @(posedge clk);
            #1 flash_erase_done = 1'b1; flash_erase_ok = ers_ok;
            @(posedge clk); #1 flash_erase_done = 1'b0;
        end
        if (go) begin
            send_byte(len[15:8]);
            send_byte(len[7:0]);
            if (len_ok)
                for (int i = 0; i < len; i++) send_byte(8'((i * 7 + 3) ^ (i >> 8)));
        end
        do @(negedge clk); while (!(start_cnt > 0 || halted));
        repeat (4) @(negedge clk);
        if (!(go && len_ok)) begin
            @(posedge clk); #1 rx_data = 8'h55; rx_valid = 1'b1;
            repeat (6) begin
                @(negedge clk);
                chk(!rx_ready && halted, "R5 halted takes nothing", {rx_ready, halted}, 1);
            end
            @(posedge clk); #1 rx_valid = 1'b0;
        end
        chk(exp_tx.size() == 0, "R6 tx stream complete", exp_tx.size(), 0);
        chk(exp_wa.size() == 0, "R8 writes complete", exp_wa.size(), 0);
        chk(start_cnt == ((go && len_ok) ? 1 : 0), "R10 start count", start_cnt, (go && len_ok) ? 1 : 0);
        chk(halted == !(go && len_ok), "R7 halted state", int'(halted), !(go && len_ok));
        if (blank) chk(erase_seen == 0, "R3 no erase when blank", erase_seen, 0);
        else chk(erase_seen == 1, "R4 erase requested", erase_seen, 1);
    endtask

    initial begin
        run(1'b1, 1'b0, 3);      // blank flash, short load
        run(1'b0, 1'b1, 910);    // erase needed, full window
        run(1'b0, 1'b0, 5);      // erase failure
        run(1'b1, 1'b0, 0);      // zero length rejected
        run(1'b1, 1'b0, 911);    // one over the limit rejected
        run(1'b1, 1'b0, 256);    // 0x01 0x00 example
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule